// File: doc/BRIEF.md
# Symbol-Period Counter with Timestamp Capture and Compare

This block keeps time in symbol periods for a low-rate wireless MAC. It holds a 32-bit counter that steps once per symbol period. When the fast clock is in use, an internal prescaler divides the system clock to make the symbol tick. When the slow real-time source is in use, an external tick input drives the counter instead. Software reaches a small register file. It can load the counter, take a beacon timestamp on command, program three compare values and read or clear the match flags.

Two capture registers latch the counter value. One is the beacon timestamp and the other is the frame-start timestamp. A manual command writes the beacon timestamp, and the frame-start and beacon event inputs write the two registers when automatic capture is enabled. Each compare unit matches either an absolute counter value or an offset from the beacon timestamp. A match raises a sticky flag and, when that unit's interrupt is enabled, its interrupt line. A single enable bit stops the counter, the prescaler and all matching.

Register map (3-bit address): 0 control, 1 match status, 2 counter, 3 beacon timestamp, 4 frame-start timestamp, 5..7 compare value of unit 0..2. Control bits: 0 enable, 1 automatic capture, 2 slow-source select, 3 manual beacon capture (self-clearing, reads 0), 4 prescaler resync (self-clearing, reads 0), 8..10 relative mode of unit 0..2, 12..14 interrupt enable of unit 0..2. All other control bits read 0.

Top module: `sym_cnt_ts`

## Requirements
- R1: While enabled with the fast source in effect, the counter steps by one every PRESC_DIV clock cycles, and it wraps from 0xFFFFFFFF to 0.
- R2: While the enable bit (control bit 0) is 0, the counter and the prescaler hold, no match flag is set, and writes to the counter register are ignored. All other registers still accept writes.
- R3: A control write with bit 3 set copies the pre-edge counter value into the beacon timestamp at that edge. Bit 3 always reads back as 0.
- R4: A pulse on frame_start_i or beacon_i copies the counter into the frame-start or beacon timestamp only while control bit 1 is 1. Such a capture wins over a same-cycle software write to that register.
- R5: In absolute mode (control bit 8+i = 0), flag i is set at the edge where the counter steps onto compare value i. This includes the step that wraps to 0.
- R6: In relative mode (control bit 8+i = 1), the target is the beacon timestamp plus compare value i, taken modulo 2^32.
- R7: Match flags (status bits 0..2) are sticky and are cleared by writing 1 to the bit. A match in the same cycle as a clear leaves the flag set.
- R8: irq_o[i] is 1 exactly when flag i is set and interrupt enable bit 12+i is 1.
- R9: clk_slow_o is control bit 2 OR sleep_i. While it is 1, the counter advances once per rtc_tick_i pulse and the prescaler holds. When sleep_i falls, the fast source returns if bit 2 is 0.
- R10: A control write with bit 4 set returns the prescaler to phase 0 only while the fast source is in effect. Bit 4 reads back as 0.
- R11: After reset, every register and output is 0.
- R12: A counter write while enabled loads the written value and overrides a same-cycle symbol tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational from address) |
| frame_start_i | input | 1 | Frame-start event pulse |
| beacon_i | input | 1 | Beacon-received event pulse |
| sleep_i | input | 1 | Radio sleep indication, forces the slow source |
| rtc_tick_i | input | 1 | One-cycle symbol tick from the slow source |
| clk_slow_o | output | 1 | Slow source currently in effect |
| irq_o | output | 3 | Per-unit compare interrupt |

## Verification
Two pairs of events can land on the same edge. In the first, a match flag is set by a counter step while software writes 1 to clear that flag. The bench provokes this with the slow source selected and an rtc_tick_i pulse that lands in the cycle of the status write. It then expects the flag to survive. In the second, a counter write coincides with a tick, and the loaded value must stand without the increment. A behavioural model tracks the prescaler phase, captures and flags on every edge, so both collisions are judged against cycle-exact expectations as well as fixed register values.

// File: rtl/sct_pkg.sv
package sct_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd1;
  localparam logic [ADDR_W-1:0] A_CNT  = 3'd2;
  localparam logic [ADDR_W-1:0] A_BTS  = 3'd3;
  localparam logic [ADDR_W-1:0] A_FTS  = 3'd4;
  localparam logic [ADDR_W-1:0] A_CMP0 = 3'd5;

  localparam int B_EN     = 0;
  localparam int B_AUTO   = 1;
  localparam int B_SLOW   = 2;
  localparam int B_MAN    = 3;
  localparam int B_RESYNC = 4;
  localparam int B_MODE   = 8;
  localparam int B_IEN    = 12;
endpackage

// File: rtl/sct_prescale.sv
module sct_prescale #(
  parameter int DIV = 4,
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          resync_i,
  output logic          tick_o,
  output logic [PW-1:0] phase_o
);
  logic [PW-1:0] phase_q;
  logic          last;

  assign last    = (phase_q == PW'(DIV - 1));
  assign tick_o  = run_i && last;
  assign phase_o = phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       phase_q <= '0;
    else if (resync_i) phase_q <= '0;
    else if (run_i)    phase_q <= last ? '0 : phase_q + PW'(1);
  end
endmodule

// File: rtl/sct_cmp_unit.sv
module sct_cmp_unit #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic [W-1:0] cnt_next_i,
  input  logic [W-1:0] cmp_i,
  input  logic [W-1:0] bts_i,
  input  logic         rel_i,
  input  logic         clr_i,
  output logic         flag_o
);
  logic [W-1:0] target;
  logic         hit;
  logic         flag_q;

  // relative target wraps modulo 2^W
  assign target = rel_i ? (bts_i + cmp_i) : cmp_i;
  assign hit    = inc_i && (cnt_next_i == target);
  assign flag_o = flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else         flag_q <= hit | (flag_q & ~clr_i);
  end
endmodule

// File: rtl/sym_cnt_ts.sv
module sym_cnt_ts
  import sct_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int NUM_CMP   = 3,
  parameter int PRESC_DIV = 4,
  localparam int PW = (PRESC_DIV > 1) ? $clog2(PRESC_DIV) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_we_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [CNT_W-1:0]   reg_wdata_i,
  output logic [CNT_W-1:0]   reg_rdata_o,
  input  logic               frame_start_i,
  input  logic               beacon_i,
  input  logic               sleep_i,
  input  logic               rtc_tick_i,
  output logic               clk_slow_o,
  output logic [NUM_CMP-1:0] irq_o
);
  logic               en_q, auto_q, slow_sel_q;
  logic [NUM_CMP-1:0] mode_q, ien_q, flag, flag_clr;
  logic [CNT_W-1:0]   cnt_q, bts_q, fts_q, cnt_next;
  logic [CNT_W-1:0]   cmp_q [NUM_CMP];

  logic wr_ctrl, wr_stat, wr_cnt, wr_bts, wr_fts;
  logic slow_eff, man_ts, resync, fast_tick, tick, cnt_wr, inc;
  logic [PW-1:0] phase;

  assign wr_ctrl = reg_we_i && (reg_addr_i == A_CTRL);
  assign wr_stat = reg_we_i && (reg_addr_i == A_STAT);
  assign wr_cnt  = reg_we_i && (reg_addr_i == A_CNT);
  assign wr_bts  = reg_we_i && (reg_addr_i == A_BTS);
  assign wr_fts  = reg_we_i && (reg_addr_i == A_FTS);

  assign slow_eff   = slow_sel_q | sleep_i;
  assign clk_slow_o = slow_eff;
  assign man_ts     = wr_ctrl && reg_wdata_i[B_MAN];
  assign resync     = wr_ctrl && reg_wdata_i[B_RESYNC] && !slow_eff;

  sct_prescale #(.DIV(PRESC_DIV)) u_presc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (en_q && !slow_eff),
    .resync_i (resync),
    .tick_o   (fast_tick),
    .phase_o  (phase)
  );

  assign tick     = fast_tick | (en_q & slow_eff & rtc_tick_i);
  assign cnt_wr   = wr_cnt && en_q;
  assign inc      = tick && !cnt_wr;
  assign cnt_next = cnt_q + CNT_W'(1);
  assign flag_clr = wr_stat ? reg_wdata_i[NUM_CMP-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q       <= 1'b0;
      auto_q     <= 1'b0;
      slow_sel_q <= 1'b0;
      mode_q     <= '0;
      ien_q      <= '0;
    end else if (wr_ctrl) begin
      en_q       <= reg_wdata_i[B_EN];
      auto_q     <= reg_wdata_i[B_AUTO];
      slow_sel_q <= reg_wdata_i[B_SLOW];
      mode_q     <= reg_wdata_i[B_MODE +: NUM_CMP];
      ien_q      <= reg_wdata_i[B_IEN +: NUM_CMP];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_wr) cnt_q <= reg_wdata_i;
    else if (inc)    cnt_q <= cnt_next;
  end

  // event capture outranks a software write to the same register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             bts_q <= '0;
    else if (man_ts || (auto_q && beacon_i)) bts_q <= cnt_q;
    else if (wr_bts)                         bts_q <= reg_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      fts_q <= '0;
    else if (auto_q && frame_start_i) fts_q <= cnt_q;
    else if (wr_fts)                  fts_q <= reg_wdata_i;
  end

  for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
    logic wr_cmp;
    assign wr_cmp = reg_we_i && (reg_addr_i == ADDR_W'(int'(A_CMP0) + i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     cmp_q[i] <= '0;
      else if (wr_cmp) cmp_q[i] <= reg_wdata_i;
    end

    sct_cmp_unit #(.W(CNT_W)) u_unit (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .inc_i      (inc),
      .cnt_next_i (cnt_next),
      .cmp_i      (cmp_q[i]),
      .bts_i      (bts_q),
      .rel_i      (mode_q[i]),
      .clr_i      (flag_clr[i]),
      .flag_o     (flag[i])
    );
  end

  assign irq_o = flag & ien_q;

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      A_CTRL: begin
        reg_rdata_o[B_EN]              = en_q;
        reg_rdata_o[B_AUTO]            = auto_q;
        reg_rdata_o[B_SLOW]            = slow_sel_q;
        reg_rdata_o[B_MODE +: NUM_CMP] = mode_q;
        reg_rdata_o[B_IEN +: NUM_CMP]  = ien_q;
      end
      A_STAT:  reg_rdata_o[NUM_CMP-1:0] = flag;
      A_CNT:   reg_rdata_o = cnt_q;
      A_BTS:   reg_rdata_o = bts_q;
      A_FTS:   reg_rdata_o = fts_q;
      default: begin
        for (int i = 0; i < NUM_CMP; i++)
          if (reg_addr_i == ADDR_W'(int'(A_CMP0) + i)) reg_rdata_o = cmp_q[i];
      end
    endcase
  end
endmodule

// File: rtl/sym_cnt_ts_chk.sv
module sym_cnt_ts_chk #(
  parameter int CNT_W   = 32,
  parameter int NUM_CMP = 3,
  parameter int PW      = 2
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               en_q,
  input logic               slow_eff,
  input logic               cnt_wr,
  input logic               man_ts,
  input logic               resync,
  input logic [PW-1:0]      phase,
  input logic [CNT_W-1:0]   cnt_q,
  input logic [CNT_W-1:0]   bts_q,
  input logic [NUM_CMP-1:0] flag,
  input logic [NUM_CMP-1:0] flag_clr
);
  AST_CNT_HOLD_DIS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |=> $stable(cnt_q)); // R2

  AST_NO_MATCH_DIS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |=> ((flag & ~$past(flag)) == '0)); // R2

  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && !cnt_wr) |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + CNT_W'(1))); // R1

  AST_MAN_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    man_ts |=> (bts_q == $past(cnt_q))); // R3

  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(flag & ~flag_clr) & ~flag) == '0)); // R7

  AST_PHASE_HOLD_SLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slow_eff && !resync) |=> $stable(phase)); // R9
endmodule

bind sym_cnt_ts sym_cnt_ts_chk #(.CNT_W(CNT_W), .NUM_CMP(NUM_CMP), .PW(PW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .en_q     (en_q),
  .slow_eff (slow_eff),
  .cnt_wr   (cnt_wr),
  .man_ts   (man_ts),
  .resync   (resync),
  .phase    (phase),
  .cnt_q    (cnt_q),
  .bts_q    (bts_q),
  .flag     (flag),
  .flag_clr (flag_clr)
);

// File: tb/sym_cnt_ts_bench.sv
`timescale 1ns/1ps
module sym_cnt_ts_bench;
  localparam int DIV = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        frm = 1'b0, bcn = 1'b0, slp = 1'b0, rtc = 1'b0;
  logic        slow_o;
  logic [2:0]  irq;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  sym_cnt_ts #(.PRESC_DIV(DIV)) u_sym_cnt_ts (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .frame_start_i(frm),
    .beacon_i(bcn), .sleep_i(slp), .rtc_tick_i(rtc),
    .clk_slow_o(slow_o), .irq_o(irq)
  );

  // behavioural reference model
  logic [31:0] m_cnt, m_bts, m_fts, m_ctrl;
  logic [31:0] m_cmp [3];
  logic [2:0]  m_flag;
  int          m_pre;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_bts = 0; m_fts = 0; m_ctrl = 0; m_flag = 0; m_pre = 0;
      for (int i = 0; i < 3; i++) m_cmp[i] = 0;
    end else begin
      automatic bit en   = m_ctrl[0];
      automatic bit slow = m_ctrl[2] | slp;
      automatic bit tk   = (en && !slow && m_pre == DIV-1) || (en && slow && rtc);
      automatic bit cwr  = we && addr == 2 && en;
      automatic bit step = tk && !cwr;
      automatic logic [31:0] nxt = m_cnt + 1;
      automatic logic [31:0] old = m_cnt;
      automatic logic [2:0] nf;
      for (int i = 0; i < 3; i++) begin
        automatic logic [31:0] tg = m_ctrl[8+i] ? m_bts + m_cmp[i] : m_cmp[i];
        automatic bit clr = we && addr == 1 && wdata[i];
        nf[i] = (step && nxt == tg) || (m_flag[i] && !clr);
      end
      if (we && addr == 0 && wdata[4] && !slow) m_pre = 0;
      else if (en && !slow) m_pre = (m_pre + 1) % DIV;
      if ((we && addr == 0 && wdata[3]) || (m_ctrl[1] && bcn)) m_bts = old;
      else if (we && addr == 3) m_bts = wdata;
      if (m_ctrl[1] && frm) m_fts = old;
      else if (we && addr == 4) m_fts = wdata;
      for (int i = 0; i < 3; i++) if (we && addr == 3'(5+i)) m_cmp[i] = wdata;
      if (cwr) m_cnt = wdata; else if (step) m_cnt = nxt;
      m_flag = nf;
      if (we && addr == 0) m_ctrl = wdata & 32'h0000_7707;
    end
  end

  function automatic logic [31:0] m_rd(input logic [2:0] a);
    case (a)
      0: return m_ctrl;
      1: return {29'd0, m_flag};
      2: return m_cnt;
      3: return m_bts;
      4: return m_fts;
      default: return m_cmp[a-5];
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison of address-independent outputs
  always @(negedge clk) begin
    #0.1;
    if (rst_n) begin
      chk(irq == (m_flag & m_ctrl[14:12]), "R8 irq vs model", {29'd0, irq}, {29'd0, m_flag & m_ctrl[14:12]});
      chk(slow_o == (m_ctrl[2] | slp), "R9 slow vs model", {31'd0, slow_o}, {31'd0, m_ctrl[2] | slp});
    end
  end

  task automatic cyc(input bit w, input logic [2:0] a, input logic [31:0] d,
                     input bit r = 0, input bit b = 0, input bit f = 0);
    we = w; addr = a; wdata = d; rtc = r; bcn = b; frm = f;
    @(negedge clk);
    we = 0; rtc = 0; bcn = 0; frm = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
    addr = a;
    #0.2;
    chk(rdata == exp, tag, rdata, exp);
    chk(rdata == m_rd(a), {tag, " model"}, rdata, m_rd(a));
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R11 reset state
    rd(0, 0, "R11 ctrl"); rd(1, 0, "R11 stat"); rd(2, 0, "R11 cnt");
    rd(3, 0, "R11 bts"); rd(6, 0, "R11 cmp1");
    chk(irq == 0 && slow_o == 0, "R11 outputs", {28'd0, slow_o, irq}, 0);
    // R2 counter write ignored while disabled, others writable
    cyc(1, 2, 100);
    rd(2, 0, "R2 cnt write ignored");
    cyc(1, 5, 6);
    rd(5, 6, "R2 cmp0 writable");
    // R1/R5/R8 fast counting and absolute match
    cyc(1, 0, 32'h1001);
    idle(23);
    rd(2, 5, "R1 cnt after 23 cycles");
    rd(1, 0, "R5 no early match");
    idle(1);
    rd(2, 6, "R1 cnt after 24 cycles");
    rd(1, 1, "R5 abs match unit0");
    chk(irq == 3'b001, "R8 irq0 enabled", {29'd0, irq}, 1);
    // R7 clear
    cyc(1, 1, 1);
    rd(1, 0, "R7 w1c clear");
    // R3/R6 manual timestamp with relative mode
    cyc(1, 6, 3);
    cyc(1, 0, 32'h120D);
    rd(3, 6, "R3 manual capture");
    rd(0, 32'h1205, "R3 self-clear bit reads 0");
    cyc(0, 0, 0, 1); cyc(0, 0, 0, 1);
    rd(1, 0, "R6 no match before target");
    cyc(0, 0, 0, 1);
    rd(2, 9, "R9 rtc ticks count");
    rd(1, 2, "R6 relative match unit1");
    chk(irq == 0, "R8 irq1 masked", {29'd0, irq}, 0);
    idle(10);
    rd(2, 9, "R9 prescaler ignored when slow");
    // R7 set and clear in same cycle
    cyc(1, 5, 10);
    cyc(1, 1, 1, 1);
    rd(1, 3, "R7 set wins over clear");
    cyc(1, 1, 3);
    rd(1, 0, "R7 clear both");
    // R4 automatic capture gating
    cyc(0, 0, 0, 0, 1, 1);
    rd(3, 6, "R4 beacon ignored when auto off");
    rd(4, 0, "R4 frame ignored when auto off");
    cyc(1, 0, 32'h1207);
    cyc(0, 0, 0, 0, 0, 1);
    rd(4, 10, "R4 frame capture");
    we = 1; addr = 3; wdata = 32'h55; bcn = 1;
    @(negedge clk); we = 0; bcn = 0;
    rd(3, 10, "R4 beacon capture beats write");
    // R9 sleep forces slow source
    slp = 1;
    cyc(1, 0, 32'h1203);
    chk(slow_o == 1, "R9 sleep forces slow", {31'd0, slow_o}, 1);
    cyc(0, 0, 0, 1);
    rd(2, 11, "R9 rtc tick during sleep");
    slp = 0;
    #0.2;
    chk(slow_o == 0, "R9 fast after wake", {31'd0, slow_o}, 0);
    idle(1);
    rd(2, 12, "R9 fast tick resumes");
    idle(1);
    // R10 resync
    cyc(1, 0, 32'h1213);
    idle(3);
    rd(2, 12, "R10 resync restarts phase");
    rd(0, 32'h1203, "R10 resync bit reads 0");
    idle(1);
    rd(2, 13, "R10 tick after full period");
    rd(1, 2, "R6 relative match after recapture");
    // R12 write beats tick; R1/R5 wrap match
    cyc(1, 0, 32'h4005);
    cyc(1, 2, 32'hFFFF_FFFF, 1);
    rd(2, 32'hFFFF_FFFF, "R12 write overrides tick");
    cyc(0, 0, 0, 1);
    rd(2, 0, "R1 wrap to zero");
    rd(1, 6, "R5 match on wrap");
    chk(irq == 3'b100, "R8 irq2 only", {29'd0, irq}, 4);
    // R2 disabled holds
    cyc(1, 0, 4);
    cyc(0, 0, 0, 1); cyc(0, 0, 0, 1);
    idle(5);
    cyc(1, 2, 5);
    rd(2, 0, "R2 counter held and write ignored");
    rd(1, 6, "R2 flags unchanged");
    idle(2);
    summary();
    $finish;
  end
endmodule